// File: doc/BRIEF.md
# Duty Ratio Best-Fit Search Engine

This block searches for the pair of 8-bit throttle counts, a run count (OFF) and a halt count (ON), whose modulated clock rate comes closest to a requested rate. The achieved rate for a pair is the full-speed (stock) rate scaled by OFF/(OFF+ON). The engine tries every total period from a programmable maximum down to 1. For each period it derives the OFF count from the target, the ON count as the rest of the period, and the rate that this pair really yields. It keeps the candidate with the smallest absolute error.

A caller loads target, stock and maximum period and pulses `start_i`. The engine raises `busy_o` and walks the periods one after another. A single restoring divider is shared by the two divisions that each candidate needs. When the scan is over the engine pulses `done_o` for one cycle. The chosen counts and rate then hold on the outputs until the next accepted start. On an equal error the later candidate wins, so among equally good fits the shortest period is reported, which gives the lowest modulation latency.

The controller has five states. `ST_IDLE` waits for a start. `ST_OFF_DIV` divides target×period by stock. `ST_FRQ_DIV` divides stock×OFF by period. `ST_PICK` compares the candidate and steps the period. `ST_DONE` pulses done. The transitions are:
- `ST_IDLE`→`ST_OFF_DIV` on a start with a usable stock and period.
- `ST_IDLE`→`ST_DONE` on a start with stock zero or period zero.
- `ST_OFF_DIV`→`ST_FRQ_DIV` and `ST_FRQ_DIV`→`ST_PICK` when the divider finishes.
- `ST_PICK`→`ST_OFF_DIV` while the period is above 1.
- `ST_PICK`→`ST_DONE` after period 1.
- `ST_DONE`→`ST_IDLE` always.

Top module: `duty_fit_engine`

## Requirements
- R1: Candidate periods run from the maximum period down to 1 inclusive. A maximum above 255 acts exactly as 255. A maximum of 0 tries no candidate and reports the initial values.
- R2: For period i, OFF is the low 8 bits of floor(target×i / stock), and ON is (i − OFF) modulo 256.
- R3: A candidate's rate is floor(stock×OFF / i), computed without overflow for a 32-bit stock and an 8-bit OFF.
- R4: A candidate replaces the current best when its absolute error to the target is less than or equal to the best error. Ties therefore go to the smaller period.
- R5: Before the scan, the best result is OFF = 1, ON = 0 and rate = stock.
- R6: `busy_o` is high from the cycle after an accepted start until the scan ends. `done_o` is high for exactly one cycle, with `busy_o` low. The outputs stay unchanged from that cycle until the next accepted start. After reset, busy, done and all outputs are 0.
- R7: A start while busy is ignored. The running search finishes with its own inputs and gives a single done pulse.
- R8: A stock of zero ends the search at once: done comes in the first cycle after the start, with OFF = 1, ON = 0 and rate 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| target_i | input | 32 | Requested rate |
| stock_i | input | 32 | Full-speed rate |
| max_per_i | input | 16 | Largest period to try, clamped to 255 |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle end-of-search pulse |
| off_o | output | 8 | Chosen OFF (run) count |
| on_o | output | 8 | Chosen ON (halt) count |
| freq_o | output | 40 | Rate achieved by the chosen pair |

## Verification
The bench builds the engine with its default widths: 32-bit rates, 8-bit counts and a 16-bit maximum-period input. This puts the 255 clamp in reach, since inputs such as 300 can be driven, and a full 255-period scan finishes in tens of thousands of cycles. The 40-bit rate output lets targets above stock be tried, where OFF can exceed the period. Short maximum periods keep most vectors quick. A few full-length scans cover the tie rule at the smallest period and the clamp.

// File: rtl/duty_fit_pkg.sv
package duty_fit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OFF_DIV,
        ST_FRQ_DIV,
        ST_PICK,
        ST_DONE
    } fit_state_t;

    function automatic logic [63:0] abs_gap(input logic [63:0] a, input logic [63:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/fit_divider.sv
module fit_divider #(
    parameter int W = 40
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         go_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] quo_o,
    output logic         fin_o
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, quo_q, num_q, den_q;
    logic [CW-1:0] left_q;
    logic          run_q;
    logic [W:0]    shifted;
    logic [W+1:0]  trial;

    assign shifted = {rem_q, quo_q[W-1]};
    assign trial   = {1'b0, shifted} - {2'b00, den_q};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rem_q  <= '0;
            quo_q  <= '0;
            num_q  <= '0;
            den_q  <= '0;
            left_q <= '0;
            run_q  <= 1'b0;
            fin_o  <= 1'b0;
        end else begin
            fin_o <= 1'b0;
            if (go_i) begin
                rem_q  <= '0;
                quo_q  <= num_i;
                num_q  <= num_i;
                den_q  <= den_i;
                left_q <= CW'(W);
                run_q  <= 1'b1;
            end else if (run_q) begin
                if (!trial[W+1]) begin
                    rem_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                left_q <= left_q - 1'b1;
                if (left_q == CW'(1)) begin
                    run_q <= 1'b0;
                    fin_o <= 1'b1;
                end
            end
        end
    end

    assign quo_o = quo_q;

    logic [2*W-1:0] back_prod;
    assign back_prod = (2*W)'(quo_q) * (2*W)'(den_q);

    // R2 R3
    quotient_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fin_o |-> (back_prod <= (2*W)'(num_q)) &&
                  (((2*W)'(num_q) - back_prod) < (2*W)'(den_q)));

endmodule

// File: rtl/fit_cand_eval.sv
module fit_cand_eval #(
    parameter int W = 40
) (
    input  logic [W-1:0] cand_i,
    input  logic [W-1:0] target_i,
    input  logic [W-1:0] best_err_i,
    output logic [W-1:0] cand_err_o,
    output logic         take_o
);
    always_comb begin
        cand_err_o = (cand_i >= target_i) ? (cand_i - target_i) : (target_i - cand_i);
        take_o     = (cand_err_o <= best_err_i);
    end
endmodule

// File: rtl/duty_fit_engine.sv
module duty_fit_engine
    import duty_fit_pkg::*;
#(
    parameter int FREQ_W  = 32,
    parameter int CNT_W   = 8,
    parameter int MAXIN_W = 16
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      start_i,
    input  logic [FREQ_W-1:0]         target_i,
    input  logic [FREQ_W-1:0]         stock_i,
    input  logic [MAXIN_W-1:0]        max_per_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [CNT_W-1:0]          off_o,
    output logic [CNT_W-1:0]          on_o,
    output logic [FREQ_W+CNT_W-1:0]   freq_o
);
    localparam int PROD_W = FREQ_W + CNT_W;
    localparam int PER_CAP = (1 << CNT_W) - 1;

    fit_state_t state_q, state_d;

    logic [FREQ_W-1:0] tgt_q, stk_q;
    logic [CNT_W-1:0]  per_q, off_q, on_q;
    logic [PROD_W-1:0] cand_q;
    logic [CNT_W-1:0]  best_off_q, best_on_q;
    logic [PROD_W-1:0] best_frq_q, best_err_q;
    logic              div_go_q;

    logic [CNT_W-1:0]  per_clamped;
    logic              early_exit;
    logic [PROD_W-1:0] div_num, div_den, div_quo;
    logic              div_fin;
    logic [PROD_W-1:0] cand_err;
    logic              cand_take;

    assign per_clamped = (max_per_i > MAXIN_W'(PER_CAP)) ? CNT_W'(PER_CAP)
                                                         : max_per_i[CNT_W-1:0];
    assign early_exit  = (stock_i == '0) || (per_clamped == '0);

    always_comb begin
        if (state_q == ST_OFF_DIV) begin
            div_num = PROD_W'(tgt_q) * PROD_W'(per_q);
            div_den = PROD_W'(stk_q);
        end else begin
            div_num = PROD_W'(stk_q) * PROD_W'(off_q);
            div_den = PROD_W'(per_q);
        end
    end

    fit_divider #(.W(PROD_W)) div_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .go_i  (div_go_q),
        .num_i (div_num),
        .den_i (div_den),
        .quo_o (div_quo),
        .fin_o (div_fin)
    );

    fit_cand_eval #(.W(PROD_W)) eval_i (
        .cand_i    (cand_q),
        .target_i  (PROD_W'(tgt_q)),
        .best_err_i(best_err_q),
        .cand_err_o(cand_err),
        .take_o    (cand_take)
    );

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = early_exit ? ST_DONE : ST_OFF_DIV;
            ST_OFF_DIV: if (div_fin) state_d = ST_FRQ_DIV;
            ST_FRQ_DIV: if (div_fin) state_d = ST_PICK;
            ST_PICK:    state_d = (per_q == CNT_W'(1)) ? ST_DONE : ST_OFF_DIV;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tgt_q      <= '0;
            stk_q      <= '0;
            per_q      <= '0;
            off_q      <= '0;
            on_q       <= '0;
            cand_q     <= '0;
            best_off_q <= '0;
            best_on_q  <= '0;
            best_frq_q <= '0;
            best_err_q <= '0;
            div_go_q   <= 1'b0;
            off_o      <= '0;
            on_o       <= '0;
            freq_o     <= '0;
        end else begin
            div_go_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        tgt_q      <= target_i;
                        stk_q      <= stock_i;
                        per_q      <= per_clamped;
                        best_off_q <= CNT_W'(1);
                        best_on_q  <= '0;
                        best_frq_q <= PROD_W'(stock_i);
                        best_err_q <= (stock_i >= target_i) ? PROD_W'(stock_i - target_i)
                                                            : PROD_W'(target_i - stock_i);
                        if (early_exit) begin
                            off_o  <= CNT_W'(1);
                            on_o   <= '0;
                            freq_o <= PROD_W'(stock_i);
                        end else begin
                            div_go_q <= 1'b1;
                        end
                    end
                end
                ST_OFF_DIV: begin
                    if (div_fin) begin
                        off_q    <= div_quo[CNT_W-1:0];
                        on_q     <= per_q - div_quo[CNT_W-1:0];
                        div_go_q <= 1'b1;
                    end
                end
                ST_FRQ_DIV: begin
                    if (div_fin) cand_q <= div_quo;
                end
                ST_PICK: begin
                    if (cand_take) begin
                        best_off_q <= off_q;
                        best_on_q  <= on_q;
                        best_frq_q <= cand_q;
                        best_err_q <= cand_err;
                    end
                    if (per_q == CNT_W'(1)) begin
                        off_o  <= cand_take ? off_q  : best_off_q;
                        on_o   <= cand_take ? on_q   : best_on_q;
                        freq_o <= cand_take ? cand_q : best_frq_q;
                    end else begin
                        per_q    <= per_q - 1'b1;
                        div_go_q <= 1'b1;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    assign busy_o = (state_q == ST_OFF_DIV) || (state_q == ST_FRQ_DIV) || (state_q == ST_PICK);
    assign done_o = (state_q == ST_DONE);

    // R6
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R6
    busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_o && done_o));

    // R6
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !start_i) |=> $stable(freq_o) && $stable(off_o) && $stable(on_o));

    // R7
    busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> $stable(tgt_q) && $stable(stk_q));

    // R1
    period_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (per_q != '0));

    // R2
    count_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (CNT_W'(off_o + on_o) != '0));

    // R4 R5
    err_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (abs_gap(64'(freq_o), 64'(tgt_q)) <= abs_gap(64'(stk_q), 64'(tgt_q))));

endmodule

// File: tb/duty_fit_engine_tb_top.sv
`timescale 1ns/1ps
module duty_fit_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] target = '0;
    logic [31:0] stock = '0;
    logic [15:0] max_per = '0;
    logic        busy, done;
    logic [7:0]  off_c, on_c;
    logic [39:0] freq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    duty_fit_engine dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .target_i(target), .stock_i(stock), .max_per_i(max_per),
        .busy_o(busy), .done_o(done), .off_o(off_c), .on_o(on_c), .freq_o(freq)
    );

    localparam int NV = 7;
    localparam longint TV_T[NV] = '{50, 30000, 123456, 199999, 1, 350000, 7777};
    localparam longint TV_S[NV] = '{100, 200000, 400000, 200000, 1000, 200000, 33333};
    localparam longint TV_M[NV] = '{4, 40, 25, 30, 20, 12, 17};

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint labs(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    // reference from the requirements R1..R5, R8
    task automatic model(input longint t, input longint s, input longint m,
                         output longint o_off, output longint o_on, output longint o_f);
        longint mm;
        mm = (m > 255) ? 255 : m;
        o_off = 1; o_on = 0; o_f = s;
        if (s != 0) begin
            for (longint i = mm; i > 0; i--) begin
                longint c_off, c_f;
                c_off = ((t * i) / s) & 255;
                c_f = (s * c_off) / i;
                if (labs(c_f - t) <= labs(o_f - t)) begin
                    o_off = c_off;
                    o_on = (i - c_off) & 255;
                    o_f = c_f;
                end
            end
        end
    endtask

    task automatic run(input longint t, input longint s, input longint m, output int lat);
        @(negedge clk);
        target = t[31:0]; stock = s[31:0]; max_per = m[15:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 40000) begin
            @(negedge clk);
            lat++;
        end
        if (lat >= 40000) chk("watchdog", 0, 1);
    endtask

    task automatic run_check(input string req, input longint t, input longint s, input longint m);
        longint e_off, e_on, e_f;
        int lat;
        model(t, s, m, e_off, e_on, e_f);
        run(t, s, m, lat);
        chk({req, " off"}, off_c, e_off);
        chk({req, " on"}, on_c, e_on);
        chk({req, " freq"}, freq, e_f);
    endtask

    initial begin
        #(5.0 * 190000);
        chk("watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        longint a_off, a_on, a_f;
        repeat (3) @(negedge clk);
        // R6 reset state
        chk("R6 reset busy", busy, 0);
        chk("R6 reset done", done, 0);
        chk("R6 reset outputs", {off_c, on_c, freq}, 0);
        rst_n = 1'b1;

        // table walk: R2 R3 R4 R5
        for (int k = 0; k < NV; k++) run_check("R2 R3 R4 table", TV_T[k], TV_S[k], TV_M[k]);

        // R4 hand tie: 100 stock, target 50, max 4 -> period 2 wins over 4
        run(50, 100, 4, lat);
        chk("R4 tie off", off_c, 1);
        chk("R4 tie on", on_c, 1);
        chk("R4 tie freq", freq, 50);
        // R6 done one cycle, busy low, outputs held
        chk("R6 busy low at done", busy, 0);
        @(negedge clk);
        chk("R6 done single", done, 0);
        repeat (5) @(negedge clk);
        chk("R6 hold freq", freq, 50);
        chk("R6 hold done", done, 0);

        // R4 zero target: every candidate errs equally, period 1 wins
        run(0, 5000, 10, lat);
        chk("R4 zero off", off_c, 0);
        chk("R4 zero on", on_c, 1);
        chk("R4 zero freq", freq, 0);

        // R5 R1 max zero gives initial values
        run(1234, 9000, 0, lat);
        chk("R5 init off", off_c, 1);
        chk("R5 init on", on_c, 0);
        chk("R5 init freq", freq, 9000);
        chk("R1 no scan latency", lat, 0);

        // R8 stock zero
        run(777, 0, 200, lat);
        chk("R8 off", off_c, 1);
        chk("R8 on", on_c, 0);
        chk("R8 freq", freq, 0);
        chk("R8 latency", lat, 0);

        // R7 start while busy ignored
        @(negedge clk);
        target = 50; stock = 100; max_per = 4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 busy", busy, 1);
        target = 1; stock = 300; max_per = 9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 40000) begin @(negedge clk); lat++; end
        chk("R7 off", off_c, 1);
        chk("R7 on", on_c, 1);
        chk("R7 freq", freq, 50);
        @(negedge clk);
        repeat (3) begin
            chk("R7 single done", done, 0);
            @(negedge clk);
        end
        chk("R7 no restart", busy, 0);

        // R4 R1 target equal to stock over a full scan: period 1, OFF 1
        run(200000, 200000, 255, lat);
        chk("R4 full off", off_c, 1);
        chk("R4 full on", on_c, 0);
        chk("R4 full freq", freq, 200000);

        // R1 clamp: 300 must equal 255
        run(70001, 233000, 255, lat);
        a_off = off_c; a_on = on_c; a_f = freq;
        run_check("R1 clamp model", 70001, 233000, 300);
        chk("R1 clamp off", off_c, a_off);
        chk("R1 clamp on", on_c, a_on);
        chk("R1 clamp freq", freq, a_f);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule